// File: doc/BRIEF.md
# Dual-Channel Disk Controller Register File

This block is the memory-mapped register file of a two-channel disk controller. It sits on a simple byte-addressed bus with a 512-byte window, a 32-bit data path, separate read and write strobes and a registered read-data output. Each channel has a DMA command byte, a DMA status byte, a 6-bit scratch data byte, a 32-bit DMA address, a configuration/status word that carries the channel's interrupt flag, a 12-bit serial-link control word and a 16-bit interrupt-enable field.

The DMA engine, the task-file registers and the link layer sit outside this block. They reach it through a few wires. Per-channel set strobes raise the low three status bits. A per-channel interrupt-request strobe loads the interrupt flag. A device-present level selects a fixed link-status code. The block sends back a one-cycle bus-reset pulse per channel and a single interrupt line that ORs the two channel flags. Two summary addresses gather the command, status and interrupt bits into one word, so software can poll both channels with a single read.

Top module: `dual_chan_regfile`

## Requirements
- R1: After reset, every stored field reads zero, except the configuration words, which read 0x65150000. The interrupt output, both bus-reset pulses and the read data are all 0.
- R2: A write to a status byte (channel 0 at 0x02, channel 1 at 0x0A) sets bits 6:5 to the written value. Bit 0 holds its value. Bits 2:1 clear where the written bit is 1 and hold where it is 0. Bits 7, 4 and 3 read 0. A set strobe `st_set[3c+k]` sets bit k (k = 0..2) of channel c's status on the next edge.
- R3: Channel c (0 or 1) keeps its command byte at 8c+0, its data byte at 8c+1 and its status at 8c+2. Writes to 0x10+8c+0..2 reach the same three registers. A write to 8c+4 loads the whole 32-bit DMA address. A write to 8c+4+k (k = 1..3) loads only byte k from the low data byte. A read at 8c+4+k returns the address shifted right by 8k bits.
- R4: The data byte stores only bits 5:0 of a write. Offsets 0x03 and 0x0B always read 0.
- R5: A read at 0x10 returns the following. Bits 7:0 hold channel 0's command byte, with bit 4 ORed with channel 0's interrupt flag and bit 6 ORed with channel 1's. Bit 14 holds bit 2 of channel 1's status. Bits 23:16 hold channel 0's status and bits 31:24 hold channel 1's status. All other bits are 0.
- R6: A read at 0x18 returns channel 1's command byte in bits 7:0, with bit 4 ORed with channel 1's interrupt flag, and channel 1's status in bits 23:16. All other bits are 0.
- R7: A pulse on `irq_we[c]` loads `irq_lvl[c]` into channel c's flag, which is bit 11 of its configuration word, on the next edge. The output `irq` is the OR of the two flags.
- R8: The serial control words at 0x100 and 0x180 store bits 11:0 of a write. A write with bit 0 set drives `bus_rst[c]` high for exactly the following cycle.
- R9: The interrupt-enable fields at 0x148 and 0x1C8 store write-data bits 31:16 ANDed with 0x3EED. A read returns the stored field in bits 31:16, with bits 15:0 at 0.
- R10: Offsets 0x104 and 0x184 read 0x113 when `dev_present[c]` is high and 0 when it is low. The configuration words read back at 0xA0 and 0xE0.
- R11: A read at any address not listed above returns 0, and a write to such an address changes nothing. A read returns the state before the edge that samples `bus_rd`, and the data appears on `bus_rdata` after that edge. `bus_rdata` holds its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 9 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dev_present | input | 2 | Per-channel device-present level |
| irq_we | input | 2 | Per-channel interrupt-flag load strobe |
| irq_lvl | input | 2 | Value loaded into the flag |
| st_set | input | 6 | Status-bit set strobes, bits 3c+2..3c for channel c |
| bus_rst | output | 2 | Per-channel one-cycle bus-reset pulse |
| irq | output | 1 | OR of both channel interrupt flags |

## Verification
The timing of each result is fixed:
- Read data is due one edge after the read is sampled, so the bench drives a read on a falling edge and compares `bus_rdata` on the next falling edge.
- A written or set value is visible to any read issued after the write's edge.
- `bus_rst` is due one edge after the control write, and `irq` follows one edge after an `irq_we` pulse.
- The bench samples both of these on the falling edge right after that edge and checks that `bus_rst` drops again one cycle later.

Stimulus never overlaps a write, a set strobe and a read in the same cycle, so a bench model updated per access predicts every read exactly.

// File: rtl/dcrf_pkg.sv
package dcrf_pkg;
  localparam int NCH = 2;

  localparam logic [15:0] IEN_MASK     = 16'h3EED;
  localparam logic [15:0] CFG_ID       = 16'h6515;
  localparam logic [31:0] PRESENT_CODE = 32'h0000_0113;

  typedef struct packed {
    logic [7:0]  cmd;
    logic [7:0]  swd;
    logic [7:0]  st;
    logic [31:0] dadr;
    logic [11:0] sctl;
    logic [15:0] ien;
    logic        flag;
    logic        present;
  } chan_view_t;

  // status write: 6:5 loaded, 0 kept, 2:1 write-one-to-clear, rest zero
  function automatic logic [7:0] st_merge(input logic [7:0] old, input logic [7:0] w);
    return (w & 8'h60) | (old & 8'h01) | (old & ~w & 8'h06);
  endfunction

  function automatic logic [31:0] cfg_word(input logic flag);
    return {CFG_ID, 4'b0000, flag, 11'b0};
  endfunction
endpackage

// File: rtl/dcrf_chan.sv
module dcrf_chan
  import dcrf_pkg::*;
#(
  parameter int CH     = 0,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              present,
  input  logic              irq_we,
  input  logic              irq_lvl,
  input  logic [2:0]        st_set,
  output chan_view_t        view,
  output logic              bus_rst
);
  localparam int DMA_BASE   = CH * 8;
  localparam int ALIAS_BASE = 16 + CH * 8;
  localparam int LINK_BASE  = 256 + CH * 128;
  localparam int IEN_OFF    = LINK_BASE + 'h48;

  logic [7:0]  cmd_q, cmd_n, swd_q, swd_n, st_q, st_n;
  logic [31:0] dadr_q, dadr_n;
  logic [11:0] sctl_q, sctl_n;
  logic [15:0] ien_q, ien_n;
  logic        flag_q, flag_n, rst_n_pulse;

  logic wr_cmd, wr_swd, wr_st, wr_adr, wr_sctl, wr_ien;

  always_comb begin
    wr_cmd  = wr_en && (addr == ADDR_W'(DMA_BASE)     || addr == ADDR_W'(ALIAS_BASE));
    wr_swd  = wr_en && (addr == ADDR_W'(DMA_BASE + 1) || addr == ADDR_W'(ALIAS_BASE + 1));
    wr_st   = wr_en && (addr == ADDR_W'(DMA_BASE + 2) || addr == ADDR_W'(ALIAS_BASE + 2));
    wr_adr  = wr_en && (addr[ADDR_W-1:2] == (ADDR_W-2)'((DMA_BASE + 4) >> 2));
    wr_sctl = wr_en && (addr == ADDR_W'(LINK_BASE));
    wr_ien  = wr_en && (addr == ADDR_W'(IEN_OFF));
  end

  always_comb begin
    cmd_n  = cmd_q;
    swd_n  = swd_q;
    st_n   = st_q;
    dadr_n = dadr_q;
    sctl_n = sctl_q;
    ien_n  = ien_q;
    flag_n = flag_q;
    if (wr_cmd)  cmd_n = wdata[7:0];
    if (wr_swd)  swd_n = {2'b00, wdata[5:0]};
    if (wr_st)   st_n  = st_merge(st_q, wdata[7:0]);
    st_n = st_n | {5'b0, st_set};
    if (wr_adr) begin
      if (addr[1:0] == 2'd0) dadr_n = wdata;
      else                   dadr_n[8*addr[1:0] +: 8] = wdata[7:0];
    end
    if (wr_sctl) sctl_n = wdata[11:0];
    if (wr_ien)  ien_n  = wdata[31:16] & IEN_MASK;
    if (irq_we)  flag_n = irq_lvl;
    rst_n_pulse = wr_sctl && wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      swd_q   <= '0;
      st_q    <= '0;
      dadr_q  <= '0;
      sctl_q  <= '0;
      ien_q   <= '0;
      flag_q  <= 1'b0;
      bus_rst <= 1'b0;
    end else begin
      cmd_q   <= cmd_n;
      swd_q   <= swd_n;
      st_q    <= st_n;
      dadr_q  <= dadr_n;
      sctl_q  <= sctl_n;
      ien_q   <= ien_n;
      flag_q  <= flag_n;
      bus_rst <= rst_n_pulse;
    end
  end

  always_comb begin
    view.cmd     = cmd_q;
    view.swd     = swd_q;
    view.st      = st_q;
    view.dadr    = dadr_q;
    view.sctl    = sctl_q;
    view.ien     = ien_q;
    view.flag    = flag_q;
    view.present = present;
  end

  AST_SWD_LOW6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_swd |=> (swd_q == {2'b00, $past(wdata[5:0])})); // R4
  AST_ST_BIT0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && st_set == 3'b000) |=> (st_q[0] == $past(st_q[0]))); // R2
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_we |=> (flag_q == $past(irq_lvl))); // R7
  AST_RST_PULSE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sctl && wdata[0]) |=> bus_rst); // R8
  AST_RST_PULSE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_sctl && wdata[0]) |=> !bus_rst); // R8
endmodule

// File: rtl/dcrf_rdmux.sv
module dcrf_rdmux
  import dcrf_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  chan_view_t        v0,
  input  chan_view_t        v1,
  output logic [DATA_W-1:0] data
);
  localparam int SUM0_OFF = 'h10;
  localparam int SUM1_OFF = 'h18;

  chan_view_t v [NCH];
  logic [DATA_W-1:0] sum0, sum1;

  always_comb begin
    v[0] = v0;
    v[1] = v1;
    sum0 = {v1.st, v0.st, 1'b0, v1.st[2], 6'b0,
            v0.cmd | {1'b0, v1.flag, 1'b0, v0.flag, 4'b0}};
    sum1 = {8'h00, v1.st, 8'h00, v1.cmd | {3'b0, v1.flag, 4'b0}};
  end

  always_comb begin
    data = '0;
    if (addr == ADDR_W'(SUM0_OFF)) data = sum0;
    if (addr == ADDR_W'(SUM1_OFF)) data = sum1;
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(c*8))     data = {24'b0, v[c].cmd};
      if (addr == ADDR_W'(c*8 + 1)) data = {24'b0, v[c].swd};
      if (addr == ADDR_W'(c*8 + 2)) data = {24'b0, v[c].st};
      if (addr[ADDR_W-1:2] == (ADDR_W-2)'((c*8 + 4) >> 2))
        data = v[c].dadr >> (8 * addr[1:0]);
      if (addr == ADDR_W'('hA0 + c*'h40)) data = cfg_word(v[c].flag);
      if (addr == ADDR_W'(256 + c*128))   data = {20'b0, v[c].sctl};
      if (addr == ADDR_W'(260 + c*128))   data = v[c].present ? PRESENT_CODE : '0;
      if (addr == ADDR_W'(256 + 'h48 + c*128)) data = {v[c].ien, 16'b0};
    end
  end
endmodule

// File: rtl/dual_chan_regfile.sv
module dual_chan_regfile
  import dcrf_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    dev_present,
  input  logic [NCH-1:0]    irq_we,
  input  logic [NCH-1:0]    irq_lvl,
  input  logic [3*NCH-1:0]  st_set,
  output logic [NCH-1:0]    bus_rst,
  output logic              irq
);
  chan_view_t        view [NCH];
  logic [DATA_W-1:0] rd_next;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dcrf_chan #(.CH(c), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .present (dev_present[c]),
      .irq_we  (irq_we[c]),
      .irq_lvl (irq_lvl[c]),
      .st_set  (st_set[3*c +: 3]),
      .view    (view[c]),
      .bus_rst (bus_rst[c])
    );
  end

  dcrf_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
    .addr (bus_addr),
    .v0   (view[0]),
    .v1   (view[1]),
    .data (rd_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  always_comb irq = view[0].flag | view[1].flag;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R11
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_we[0] && irq_lvl[0]) |=> irq); // R7
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_we == 2'b11) && (irq_lvl == 2'b00)) |=> !irq); // R7
endmodule

// File: tb/sim_dual_chan_regfile.sv
module sim_dual_chan_regfile;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  dev_present = '0, irq_we = '0, irq_lvl = '0, bus_rst;
  logic [5:0]  st_set = '0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0]  m_cmd [2], m_swd [2], m_st [2];
  logic [31:0] m_adr [2];
  logic [11:0] m_sctl [2];
  logic [15:0] m_ien [2];
  logic        m_flag [2];

  always #(CLK_P/2) clk = ~clk;

  dual_chan_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_present(dev_present), .irq_we(irq_we), .irq_lvl(irq_lvl),
    .st_set(st_set), .bus_rst(bus_rst), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [8:0] a);
    logic [31:0] r = '0;
    int ai = int'(a);
    if (ai == 'h10)
      r = {m_st[1], m_st[0], 1'b0, m_st[1][2], 6'b0,
           m_cmd[0] | {1'b0, m_flag[1], 1'b0, m_flag[0], 4'b0}};
    if (ai == 'h18)
      r = {8'h00, m_st[1], 8'h00, m_cmd[1] | {3'b0, m_flag[1], 4'b0}};
    for (int c = 0; c < 2; c++) begin
      if (ai == c*8)     r = {24'b0, m_cmd[c]};
      if (ai == c*8 + 1) r = {24'b0, m_swd[c]};
      if (ai == c*8 + 2) r = {24'b0, m_st[c]};
      if (ai >= c*8 + 4 && ai <= c*8 + 7) r = m_adr[c] >> (8 * (ai - c*8 - 4));
      if (ai == 'hA0 + c*'h40) r = {16'h6515, 4'b0, m_flag[c], 11'b0};
      if (ai == 'h100 + c*'h80) r = {20'b0, m_sctl[c]};
      if (ai == 'h104 + c*'h80) r = dev_present[c] ? 32'h113 : 32'h0;
      if (ai == 'h148 + c*'h80) r = {m_ien[c], 16'b0};
    end
    return r;
  endfunction

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    logic [1:0] rp = '0;
    int ai = int'(a);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    for (int c = 0; c < 2; c++) begin
      if (ai == c*8 || ai == 16 + c*8)         m_cmd[c] = d[7:0];
      if (ai == c*8 + 1 || ai == 17 + c*8)     m_swd[c] = {2'b00, d[5:0]};
      if (ai == c*8 + 2 || ai == 18 + c*8)
        m_st[c] = (d[7:0] & 8'h60) | (m_st[c] & 8'h01) | (m_st[c] & ~d[7:0] & 8'h06);
      if (ai == c*8 + 4) m_adr[c] = d;
      if (ai >= c*8 + 5 && ai <= c*8 + 7) m_adr[c][8*(ai - c*8 - 4) +: 8] = d[7:0];
      if (ai == 'h100 + c*'h80) begin m_sctl[c] = d[11:0]; rp[c] = d[0]; end
      if (ai == 'h148 + c*'h80) m_ien[c] = d[31:16] & 16'h3EED;
    end
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R8 bus_rst after write", {30'b0, bus_rst}, {30'b0, rp});
  endtask

  task automatic rd(input logic [8:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    e = exp_rd(a);
    @(negedge clk);
    bus_rd = 1'b0;
    chk($sformatf("%s @%h", tag, a), bus_rdata, e);
  endtask

  task automatic stset(input int c, input logic [2:0] b);
    @(negedge clk);
    st_set[3*c +: 3] = b;
    m_st[c] = m_st[c] | {5'b0, b};
    @(negedge clk);
    st_set = '0;
  endtask

  task automatic irqev(input int c, input logic l);
    @(negedge clk);
    irq_we[c] = 1'b1; irq_lvl[c] = l;
    m_flag[c] = l;
    @(negedge clk);
    irq_we = '0;
    chk("R7 irq output", {31'b0, irq}, {31'b0, m_flag[0] | m_flag[1]});
  endtask

  function automatic logic [8:0] pick_dec(input int k);
    case (k % 24)
      0: return 9'h000;  1: return 9'h001;  2: return 9'h002;  3: return 9'h004;
      4: return 9'h005;  5: return 9'h006;  6: return 9'h007;  7: return 9'h008;
      8: return 9'h009;  9: return 9'h00A; 10: return 9'h00C; 11: return 9'h00D;
      12: return 9'h00E; 13: return 9'h00F; 14: return 9'h010; 15: return 9'h011;
      16: return 9'h012; 17: return 9'h018; 18: return 9'h019; 19: return 9'h01A;
      20: return 9'h100; 21: return 9'h180; 22: return 9'h148; default: return 9'h1C8;
    endcase
  endfunction

  function automatic logic [8:0] pick_undec(input int k);
    case (k % 8)
      0: return 9'h003; 1: return 9'h00B; 2: return 9'h013; 3: return 9'h020;
      4: return 9'h0A4; 5: return 9'h108; 6: return 9'h1FF; default: return 9'h060;
    endcase
  endfunction

  task automatic sweep(input string tag);
    for (int k = 0; k < 24; k++) if (k != 15 && k != 16 && k != 18 && k != 19) rd(pick_dec(k), tag);
    rd(9'h003, "R4 pad zero"); rd(9'h00B, "R4 pad zero");
    rd(9'h0A0, "R10 cfg0"); rd(9'h0E0, "R10 cfg1");
    rd(9'h104, "R10 present0"); rd(9'h184, "R10 present1");
    for (int k = 0; k < 8; k++) if (k > 1) rd(pick_undec(k), "R11 undecoded read");
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < 2; c++) begin
      m_cmd[c] = '0; m_swd[c] = '0; m_st[c] = '0; m_adr[c] = '0;
      m_sctl[c] = '0; m_ien[c] = '0; m_flag[c] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata reset", bus_rdata, 32'h0);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);
    chk("R1 bus_rst reset", {30'b0, bus_rst}, 32'h0);
    rd(9'h0A0, "R1 cfg0 reset"); rd(9'h0E0, "R1 cfg1 reset");
    sweep("R1 reset sweep");

    // R2 status rule
    stset(0, 3'b111);
    wr(9'h002, 32'h0000_0062);
    chk("R2 status merge", exp_rd(9'h002), 32'h65);
    rd(9'h002, "R2 status w1c");
    stset(1, 3'b110);
    wr(9'h01A, 32'h0000_00FF);
    rd(9'h00A, "R2 alias status clear");
    // R3 alias, dma address lanes
    wr(9'h010, 32'h0000_00A5); rd(9'h000, "R3 alias cmd0");
    wr(9'h00C, 32'hDEAD_BEEF); wr(9'h00E, 32'h0000_0012); rd(9'h00C, "R3 dma lane");
    rd(9'h00F, "R3 dma shift");
    // R4
    wr(9'h019, 32'hFFFF_FFFF); rd(9'h009, "R4 data low6");
    // R5 / R6 summaries
    irqev(0, 1'b1); irqev(1, 1'b1); stset(1, 3'b100);
    rd(9'h010, "R5 summary0"); rd(9'h018, "R6 summary1");
    rd(9'h0E0, "R7 cfg flag");
    irqev(0, 1'b0); irqev(1, 1'b0);
    // R8 pulse and its end
    wr(9'h180, 32'hFFFF_F001);
    @(negedge clk);
    chk("R8 pulse one cycle", {30'b0, bus_rst}, 32'h0);
    wr(9'h100, 32'h0000_0AB0); rd(9'h100, "R8 sctl 12bit");
    // R9
    wr(9'h148, 32'hFFFF_FFFF); rd(9'h148, "R9 ien mask");
    // R10
    dev_present = 2'b10; rd(9'h104, "R10 absent"); rd(9'h184, "R10 present");
    // R11 undecoded writes leave state
    for (int k = 0; k < 8; k++) wr(pick_undec(k), 32'hFFFF_FFFF);
    sweep("R11 after undecoded writes");

    // random phase
    for (int i = 0; i < 600; i++) begin
      int op = int'($urandom % 10);
      if (op < 4) wr(pick_dec(int'($urandom)), $urandom);
      else if (op == 4) wr(pick_undec(int'($urandom)), $urandom);
      else if (op == 5) stset(int'($urandom % 2), 3'($urandom));
      else if (op == 6) irqev(int'($urandom % 2), 1'($urandom));
      else if (op == 7) dev_present = 2'($urandom);
      else rd(pick_dec(int'($urandom)), "R3 R5 R6 random read");
    end
    sweep("R2 R3 R9 final sweep");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule